// File: doc/BRIEF.md
# Rotating Arbitration ID Tracker

This block holds one agent's arbitration ID on a shared interrupt bus whose arbitration priority rotates. After every arbitration the agents renumber themselves. The agent that won takes ID 0, which is now the lowest priority. Every losing agent below the top ID moves up by one. The agent sitting at the top ID takes the old ID of the winner plus one. The tracker applies this rule for its own agent, so the IDs stay unique across all agents without any central counter.

An arbitration is reported in two steps. First a strobe marks the end of arbitration and carries the winner's ID, whether this agent won, and whether the message is a low-priority delivery. These values are captured at that point. Later a result strobe reports whether the message finished without a checksum or acceptance error. The new ID is applied in the clock of that result strobe. A failed message leaves the IDs unchanged, except for a low-priority message, which renumbers anyway.

The ID can also be set directly. A write to the agent's ID register loads the written value into both that register and the arbitration ID. A level-triggered INIT deassert message reloads the arbitration ID from the stored ID register.

Top module: `arb_id_tracker`

## Requirements
- R1: After reset the arbitration ID output is 0 and no arbitration is pending.
- R2: When a captured arbitration that this agent won completes successfully, the ID becomes 0 in the cycle after the result strobe.
- R3: When a captured arbitration this agent lost completes successfully and the agent's ID is below 15, the ID increases by one.
- R4: When a lost arbitration completes successfully and the agent's ID is 15, the ID becomes the winner ID captured at the end-of-arbitration strobe plus one, modulo 16. The winner ID input is ignored at all other times.
- R5: A result strobe reporting failure (resultOk=0) for a message that is not low priority leaves the ID unchanged.
- R6: A result strobe for a captured low-priority message (lowPrioMsg=1 at the arbitration strobe) applies the update rule whatever resultOk says.
- R7: A write to the ID register (idWrEn=1) sets the arbitration ID to idWrData in the next cycle.
- R8: An INIT deassert pulse (initDeassert=1 without idWrEn) reloads the arbitration ID from the last value written to the ID register.
- R9: A result strobe with no captured arbitration pending has no effect on the ID. Each captured arbitration is consumed by exactly one result strobe.
- R10: An ID write or INIT reload wins over a result strobe in the same cycle and discards any pending arbitration, including one captured in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idWrEn | input | 1 | Write strobe for the ID register |
| idWrData | input | 4 | Value written to the ID register |
| initDeassert | input | 1 | Level-triggered INIT deassert message seen |
| arbDone | input | 1 | End-of-arbitration strobe |
| winnerId | input | 4 | Pre-arbitration ID of the winner, valid with arbDone |
| arbWon | input | 1 | This agent won, valid with arbDone |
| lowPrioMsg | input | 1 | Message is a low-priority delivery, valid with arbDone |
| resultValid | input | 1 | Message result strobe |
| resultOk | input | 1 | Message finished with no checksum or acceptance error |
| arbId | output | 4 | Current arbitration ID |

## Verification
The hardest case to reach is the wrap at the top ID. The agent's ID must be 15 and it must lose. The winner ID has to be taken from the earlier arbitration strobe and not from the result strobe. The bench reaches this case on purpose: it writes each ID value 0 to 15 through the ID register, sweeps every winner ID with every won, ok and low-priority combination, and drives the complement of the winner ID during the result strobe, so that sampling at the wrong time gives a wrong value. Collisions between a load and a result are driven in separate targeted sequences, and a follow-up result strobe shows whether the pending arbitration was discarded.

// File: rtl/arb_id_pkg.sv
package arb_id_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic writeId;     // load ID register and arbitration ID from write data
    logic reloadInit;  // reload arbitration ID from ID register
    logic capture;     // sample winner ID at end of arbitration
    logic applyUpdate; // apply rotation rule this cycle
    logic winnerSelf;  // captured arbitration was won by this agent
  } arbStrobes_t;

endpackage

// File: rtl/arb_id_ctrl.sv
module arb_id_ctrl
  import arb_id_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        idWrEn,
  input  logic        initDeassert,
  input  logic        arbDone,
  input  logic        arbWon,
  input  logic        lowPrioMsg,
  input  logic        resultValid,
  input  logic        resultOk,
  output arbStrobes_t strobes
);

  logic pendingQ;
  logic wonQ;
  logic lowPrioQ;
  logic loadAny;
  logic commitOk;

  assign loadAny  = idWrEn | initDeassert;
  assign commitOk = resultOk | lowPrioQ;

  always_comb begin
    strobes             = '0;
    strobes.writeId     = idWrEn;
    strobes.reloadInit  = initDeassert & ~idWrEn;
    strobes.capture     = arbDone & ~loadAny;
    strobes.applyUpdate = pendingQ & resultValid & commitOk & ~loadAny;
    strobes.winnerSelf  = wonQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      wonQ     <= 1'b0;
      lowPrioQ <= 1'b0;
    end else begin
      if (loadAny) begin
        pendingQ <= 1'b0;
      end else if (arbDone) begin
        pendingQ <= 1'b1;
        wonQ     <= arbWon;
        lowPrioQ <= lowPrioMsg;
      end else if (resultValid) begin
        pendingQ <= 1'b0;
      end
    end
  end

  // R9: a result consumes the pending arbitration
  p_result_consumes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && resultValid && !arbDone && !loadAny) |=> !pendingQ);

  // R10: a load discards any pending arbitration
  p_load_discards_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadAny |=> !pendingQ);

endmodule

// File: rtl/arb_id_datapath.sv
module arb_id_datapath
  import arb_id_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  arbStrobes_t     strobes,
  input  logic [ID_W-1:0] idWrData,
  input  logic [ID_W-1:0] winnerId,
  output logic [ID_W-1:0] arbId
);

  localparam logic [ID_W-1:0] TOP_ID = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] ONE    = {{(ID_W-1){1'b0}}, 1'b1};

  logic [ID_W-1:0] idRegQ;
  logic [ID_W-1:0] arbIdQ;
  logic [ID_W-1:0] winnerQ;
  logic [ID_W-1:0] rotated;

  always_comb begin
    if (strobes.winnerSelf)    rotated = '0;
    else if (arbIdQ == TOP_ID) rotated = winnerQ + ONE;
    else                       rotated = arbIdQ + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idRegQ  <= '0;
      arbIdQ  <= '0;
      winnerQ <= '0;
    end else begin
      if (strobes.capture) winnerQ <= winnerId;
      if (strobes.writeId) begin
        idRegQ <= idWrData;
        arbIdQ <= idWrData;
      end else if (strobes.reloadInit) begin
        arbIdQ <= idRegQ;
      end else if (strobes.applyUpdate) begin
        arbIdQ <= rotated;
      end
    end
  end

  assign arbId = arbIdQ;

  // R5: without a strobe the ID holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.writeId || strobes.reloadInit || strobes.applyUpdate) |=> $stable(arbIdQ));

  // R2: a successful win drops to zero
  p_win_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyUpdate && strobes.winnerSelf && !strobes.writeId && !strobes.reloadInit)
      |=> arbIdQ == '0);

  // R4: wrap from the top ID takes winner plus one
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyUpdate && !strobes.winnerSelf && arbIdQ == TOP_ID
      && !strobes.writeId && !strobes.reloadInit)
      |=> arbIdQ == ID_W'($past(winnerQ) + ONE));

  // R7: ID register write lands in the arbitration ID
  p_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeId |=> arbIdQ == $past(idWrData));

  // R8: INIT reload restores the register value
  p_init_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reloadInit |=> arbIdQ == $past(idRegQ));

endmodule

// File: rtl/arb_id_tracker.sv
module arb_id_tracker
  import arb_id_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            idWrEn,
  input  logic [ID_W-1:0] idWrData,
  input  logic            initDeassert,
  input  logic            arbDone,
  input  logic [ID_W-1:0] winnerId,
  input  logic            arbWon,
  input  logic            lowPrioMsg,
  input  logic            resultValid,
  input  logic            resultOk,
  output logic [ID_W-1:0] arbId
);

  arbStrobes_t strobes;

  arb_id_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .idWrEn       (idWrEn),
    .initDeassert (initDeassert),
    .arbDone      (arbDone),
    .arbWon       (arbWon),
    .lowPrioMsg   (lowPrioMsg),
    .resultValid  (resultValid),
    .resultOk     (resultOk),
    .strobes      (strobes)
  );

  arb_id_datapath #(.ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .idWrData (idWrData),
    .winnerId (winnerId),
    .arbId    (arbId)
  );

  // R1: ID is zero right after reset
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> arbId == '0);

endmodule

// File: tb/arb_id_tracker_tb.sv
module arb_id_tracker_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idWrEn = 1'b0;
  logic [3:0] idWrData = '0;
  logic       initDeassert = 1'b0;
  logic       arbDone = 1'b0;
  logic [3:0] winnerId = '0;
  logic       arbWon = 1'b0;
  logic       lowPrioMsg = 1'b0;
  logic       resultValid = 1'b0;
  logic       resultOk = 1'b0;
  logic [3:0] arbId;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  arb_id_tracker u_dut (
    .clk(clk), .rstN(rstN), .idWrEn(idWrEn), .idWrData(idWrData),
    .initDeassert(initDeassert), .arbDone(arbDone), .winnerId(winnerId),
    .arbWon(arbWon), .lowPrioMsg(lowPrioMsg), .resultValid(resultValid),
    .resultOk(resultOk), .arbId(arbId)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeId(input logic [3:0] v);
    @(negedge clk);
    idWrEn = 1'b1; idWrData = v;
    @(negedge clk);
    idWrEn = 1'b0; idWrData = ~v;
    check(arbId, v, "R7 id write");
  endtask

  task automatic runArb(input logic [3:0] own, input logic [3:0] w,
                        input bit won, input bit lp, input bit ok);
    logic [3:0] exp;
    string tag;
    @(negedge clk);
    arbDone = 1'b1; winnerId = w; arbWon = won; lowPrioMsg = lp;
    @(negedge clk);
    arbDone = 1'b0; winnerId = ~w; arbWon = !won; lowPrioMsg = !lp;
    resultValid = 1'b1; resultOk = ok;
    @(negedge clk);
    resultValid = 1'b0; resultOk = 1'b0;
    if (ok || lp) begin
      if (won)             begin exp = 4'd0;            tag = "R2 win"; end
      else if (own == 4'hF) begin exp = w + 4'd1;       tag = "R4 wrap"; end
      else                 begin exp = own + 4'd1;      tag = "R3 increment"; end
      if (!ok) tag = {tag, " R6 low-priority fail"};
    end else begin
      exp = own; tag = "R5 failure hold";
    end
    check(arbId, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(arbId, 4'd0, "R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check(arbId, 4'd0, "R1 after reset");

    // R9: result with nothing pending
    resultValid = 1'b1; resultOk = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; resultOk = 1'b0;
    @(negedge clk);
    check(arbId, 4'd0, "R9 result without arbitration");

    // Sweep of own ID, winner ID and result combinations
    for (int own = 0; own < 16; own++) begin
      for (int w = 0; w < 16; w++) begin
        for (int m = 0; m < 8; m++) begin
          writeId(4'(own));
          runArb(4'(own), 4'(w), m[0], m[1], m[2]);
        end
      end
    end

    // R8: INIT deassert reloads from ID register
    writeId(4'd9);
    runArb(4'd9, 4'd3, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    initDeassert = 1'b1;
    @(negedge clk);
    initDeassert = 1'b0;
    check(arbId, 4'd9, "R8 init reload");

    // R10: write colliding with result discards the arbitration
    writeId(4'd4);
    @(negedge clk);
    arbDone = 1'b1; winnerId = 4'd2; arbWon = 1'b0; lowPrioMsg = 1'b0;
    @(negedge clk);
    arbDone = 1'b0;
    resultValid = 1'b1; resultOk = 1'b1; idWrEn = 1'b1; idWrData = 4'd12;
    @(negedge clk);
    resultValid = 1'b0; idWrEn = 1'b0;
    check(arbId, 4'd12, "R10 write beats result");
    resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; resultOk = 1'b0;
    @(negedge clk);
    check(arbId, 4'd12, "R10 pending discarded R9");

    // R10: INIT in the same cycle as the arbitration strobe
    writeId(4'd6);
    runArb(4'd6, 4'd1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    arbDone = 1'b1; initDeassert = 1'b1; winnerId = 4'd0; arbWon = 1'b1;
    @(negedge clk);
    arbDone = 1'b0; initDeassert = 1'b0;
    check(arbId, 4'd6, "R10 init reload with arbitration");
    resultValid = 1'b1; resultOk = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; resultOk = 1'b0;
    @(negedge clk);
    check(arbId, 4'd6, "R10 same-cycle capture dropped");

    // R9: one arbitration, two results
    writeId(4'd2);
    runArb(4'd2, 4'd5, 1'b0, 1'b0, 1'b1);
    resultValid = 1'b1; resultOk = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; resultOk = 1'b0;
    @(negedge clk);
    check(arbId, 4'd3, "R9 second result ignored");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule